// File: doc/BRIEF.md
# Monochrome Panel Bring-Up and Page Refresh Controller

This block sits between a byte-level I2C master and a 1024-byte framebuffer and keeps a 128x64 single-colour OLED panel alive. After reset it waits a programmable number of clock cycles, then sends one command transaction that holds the fixed start-up command list. From then on it writes the whole framebuffer as eight pages. For each page it sends a short command transaction that selects the page and sets the column to zero, then a data transaction that streams the 128 bytes of that page. Refresh starts on a one-cycle `frame_req` while idle, or runs back to back while `auto_refresh` is high.

The master handshake uses three single-cycle request pulses: `m_start`, `m_write` and `m_stop`. The master captures `m_byte` in the cycle `m_write` is high. It answers every request with a one-cycle `m_done`, and `m_ack_err` is valid alongside it. A refused acknowledge aborts the transaction with a STOP, sets `link_err` and restarts from the power-up wait.

The controller states are POWERUP, IDLE, START, ADDR, CTRL, BODY, STOP and ABORT:
- POWERUP goes to START (start-up list) when the delay expires.
- IDLE goes to START (page command) on a request or on auto-refresh.
- START goes to ADDR on done.
- ADDR goes to CTRL on done.
- CTRL goes to BODY on done.
- BODY stays in BODY until the last byte is done, then goes to STOP.
- From ADDR, CTRL or BODY, an acknowledge error goes to ABORT.
- STOP goes to IDLE after the start-up list, to START (data) after a page command, to START (next page command) after a data transaction on pages 0 to 6, and to IDLE after page 7.
- ABORT goes to POWERUP on done.

Top module: `oled_refresh_seq`

## Requirements
- R1: After reset no request is issued for at least PWRUP_CYCLES clock cycles, and the first request is a START.
- R2: Every transaction's first byte is the write address, 0x78 when `slave_sel`=0 (device 0x3C) and 0x7A when `slave_sel`=1 (device 0x3D).
- R3: The start-up transaction is START, address, control 0x00, then the 25 bytes AE D5 80 A8 3F D3 00 40 8D 14 20 02 A1 C8 DA 12 81 CF D9 F1 DB 40 A4 A6 AF in that order, then STOP. It is sent once after every power-up wait.
- R4: With `orient_en`=0 the bytes at positions 12 and 13 of that list become A0 and C0 instead of A1 and C8. Nothing else changes.
- R5: Each page p begins with a command transaction: START, address, 0x00, 0xB0|p, 0x00, 0x10, STOP.
- R6: A data transaction follows each page command: START, address, 0x40, then exactly 128 bytes, byte c being framebuffer word p*128+c, then STOP. `fb_rd_en` with that address is high exactly one cycle before the matching `m_write`, and the memory returns data one cycle after the read.
- R7: Pages go out in order 0 to 7. `frame_done` pulses for one cycle with the `m_done` of the STOP that ends page 7.
- R8: In IDLE a frame starts only on `frame_req` or `auto_refresh`. With both low no request is issued.
- R9: An `m_ack_err` on a written byte causes a STOP as the next request, then sets `link_err`, then a full power-up wait and start-up transaction. No frame_done is given for the aborted frame.
- R10: `link_err` clears at the next `frame_done`.
- R11: At most one request is high in any cycle, and no new request is issued until the previous one has received `m_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_sel | input | 1 | Device address select: 0 gives 0x3C, 1 gives 0x3D |
| orient_en | input | 1 | 1 sends segment remap and COM scan reversal; 0 sends their plain forms |
| auto_refresh | input | 1 | Refresh continuously while high |
| frame_req | input | 1 | One-cycle request for a single frame, used in IDLE |
| m_start | output | 1 | Request a START condition |
| m_write | output | 1 | Request a byte write of m_byte |
| m_stop | output | 1 | Request a STOP condition |
| m_byte | output | 8 | Byte for the write request |
| m_done | input | 1 | Master finished the current request |
| m_ack_err | input | 1 | With m_done: the byte was not acknowledged |
| fb_rd_en | output | 1 | Framebuffer read strobe |
| fb_addr | output | FB_AW (10) | Framebuffer read address, page*128+column |
| fb_rd_data | input | 8 | Framebuffer data, one cycle after fb_rd_en |
| frame_done | output | 1 | One-cycle pulse after page 7 completes |
| link_err | output | 1 | Set on an acknowledge error, cleared at frame_done |

## Verification
The hardest case to reach is an acknowledge failure in the middle of a frame, after one page has completed and while the next page's command transaction is starting. Several things must be seen together there: the abort STOP, the absence of frame_done, the full power-up wait and a fresh start-up list. The stimulus gets there with the bench's master model. It counts write requests after being armed and refuses only the 136th one, which is the address byte of page 1's command transaction. The scoreboard queue then holds page 0, the aborted prefix, the STOP and the start-up list in that order.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_CTRL,
        ST_BODY,
        ST_STOP,
        ST_ABORT
    } seq_state_t;

    typedef enum logic [1:0] {
        TX_INIT,
        TX_PCMD,
        TX_PDATA
    } tx_kind_t;

    localparam int       INIT_LEN   = 25;
    localparam int       PCMD_LEN   = 3;
    localparam int       PANEL_COLS = 128;
    localparam int       PANEL_PAGES = 8;
    localparam logic [7:0] CTRL_CMD  = 8'h00;
    localparam logic [7:0] CTRL_DATA = 8'h40;
    localparam logic [6:0] DEV_ADDR_LO = 7'h3C;
    localparam logic [6:0] DEV_ADDR_HI = 7'h3D;
    localparam logic [7:0] PAGE_SEL_BASE = 8'hB0;
    localparam logic [7:0] COL_LOW_ZERO  = 8'h00;
    localparam logic [7:0] COL_HIGH_ZERO = 8'h10;

endpackage

// File: rtl/oled_init_table.sv
module oled_init_table #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             orient_en,
    output logic [7:0]       cmd_byte
);
    always_comb begin
        unique case (int'(idx))
            0:  cmd_byte = 8'hAE;
            1:  cmd_byte = 8'hD5;
            2:  cmd_byte = 8'h80;
            3:  cmd_byte = 8'hA8;
            4:  cmd_byte = 8'h3F;
            5:  cmd_byte = 8'hD3;
            6:  cmd_byte = 8'h00;
            7:  cmd_byte = 8'h40;
            8:  cmd_byte = 8'h8D;
            9:  cmd_byte = 8'h14;
            10: cmd_byte = 8'h20;
            11: cmd_byte = 8'h02;
            12: cmd_byte = orient_en ? 8'hA1 : 8'hA0;
            13: cmd_byte = orient_en ? 8'hC8 : 8'hC0;
            14: cmd_byte = 8'hDA;
            15: cmd_byte = 8'h12;
            16: cmd_byte = 8'h81;
            17: cmd_byte = 8'hCF;
            18: cmd_byte = 8'hD9;
            19: cmd_byte = 8'hF1;
            20: cmd_byte = 8'hDB;
            21: cmd_byte = 8'h40;
            22: cmd_byte = 8'hA4;
            23: cmd_byte = 8'hA6;
            24: cmd_byte = 8'hAF;
            default: cmd_byte = 8'hE3;
        endcase
    end
endmodule

// File: rtl/oled_pwrup_timer.sv
module oled_pwrup_timer #(
    parameter int CYCLES = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/oled_page_cursor.sv
module oled_page_cursor #(
    parameter int PAGES = 8,
    parameter int IDX_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      idx_clr,
    input  logic                      idx_inc,
    input  logic                      page_clr,
    input  logic                      page_inc,
    output logic [IDX_W-1:0]          idx,
    output logic [$clog2(PAGES)-1:0]  page,
    output logic                      last_page
);
    localparam int PAGE_W = $clog2(PAGES);
    localparam logic [PAGE_W-1:0] PAGE_LAST = PAGE_W'(PAGES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || idx_clr) begin
            idx <= '0;
        end else if (idx_inc) begin
            idx <= idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || page_clr) begin
            page <= '0;
        end else if (page_inc) begin
            page <= page + 1'b1;
        end
    end

    assign last_page = (page == PAGE_LAST);
endmodule

// File: rtl/oled_refresh_seq.sv
module oled_refresh_seq
    import oled_seq_pkg::*;
#(
    parameter int PWRUP_CYCLES = 150000,
    parameter int COLS         = PANEL_COLS,
    parameter int PAGES        = PANEL_PAGES,
    parameter int FB_AW        = $clog2(COLS * PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave_sel,
    input  logic             orient_en,
    input  logic             auto_refresh,
    input  logic             frame_req,
    output logic             m_start,
    output logic             m_write,
    output logic             m_stop,
    output logic [7:0]       m_byte,
    input  logic             m_done,
    input  logic             m_ack_err,
    output logic             fb_rd_en,
    output logic [FB_AW-1:0] fb_addr,
    input  logic [7:0]       fb_rd_data,
    output logic             frame_done,
    output logic             link_err
);
    localparam int IDX_W  = $clog2((COLS > INIT_LEN) ? COLS : INIT_LEN) + 1;
    localparam int PAGE_W = $clog2(PAGES);

    seq_state_t       state_q;
    tx_kind_t         kind_q;
    logic             issued_q;
    logic             err_q;

    logic             tmr_run;
    logic             tmr_expired;
    logic             idx_clr;
    logic             idx_inc;
    logic             page_clr;
    logic             page_inc;
    logic [IDX_W-1:0] idx;
    logic [PAGE_W-1:0] page;
    logic             last_page;
    logic [7:0]       init_byte;
    logic             last_byte;
    logic             ack_fail;
    logic             req_any;
    int               body_len;
    logic [IDX_W-1:0] rd_col;

    oled_pwrup_timer #(.CYCLES(PWRUP_CYCLES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    oled_page_cursor #(.PAGES(PAGES), .IDX_W(IDX_W)) cursor_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_clr   (idx_clr),
        .idx_inc   (idx_inc),
        .page_clr  (page_clr),
        .page_inc  (page_inc),
        .idx       (idx),
        .page      (page),
        .last_page (last_page)
    );

    oled_init_table #(.IDX_W(IDX_W)) table_i (
        .idx       (idx),
        .orient_en (orient_en),
        .cmd_byte  (init_byte)
    );

    always_comb begin
        unique case (kind_q)
            TX_INIT:  body_len = INIT_LEN;
            TX_PCMD:  body_len = PCMD_LEN;
            default:  body_len = COLS;
        endcase
    end

    assign last_byte = (int'(idx) == body_len - 1);
    assign ack_fail  = m_done && m_ack_err &&
                       (state_q == ST_ADDR || state_q == ST_CTRL || state_q == ST_BODY);

    assign tmr_run  = (state_q == ST_POWERUP);
    assign idx_clr  = (state_q == ST_CTRL);
    assign idx_inc  = (state_q == ST_BODY) && m_done && !m_ack_err;
    assign page_clr = (state_q == ST_IDLE) || (state_q == ST_POWERUP);
    assign page_inc = (state_q == ST_STOP) && m_done && (kind_q == TX_PDATA) && !last_page;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_POWERUP;
            kind_q   <= TX_INIT;
            issued_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (req_any) begin
                issued_q <= 1'b1;
            end
            if (ack_fail) begin
                err_q <= 1'b1;
            end else if (frame_done) begin
                err_q <= 1'b0;
            end
            unique case (state_q)
                ST_POWERUP: begin
                    if (tmr_expired) begin
                        state_q <= ST_START;
                        kind_q  <= TX_INIT;
                    end
                end
                ST_IDLE: begin
                    if (frame_req || auto_refresh) begin
                        state_q <= ST_START;
                        kind_q  <= TX_PCMD;
                    end
                end
                ST_START: begin
                    if (m_done) begin
                        issued_q <= 1'b0;
                        state_q  <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (m_done) begin
                        issued_q <= 1'b0;
                        state_q  <= m_ack_err ? ST_ABORT : ST_CTRL;
                    end
                end
                ST_CTRL: begin
                    if (m_done) begin
                        issued_q <= 1'b0;
                        state_q  <= m_ack_err ? ST_ABORT : ST_BODY;
                    end
                end
                ST_BODY: begin
                    if (m_done) begin
                        issued_q <= 1'b0;
                        if (m_ack_err) begin
                            state_q <= ST_ABORT;
                        end else if (last_byte) begin
                            state_q <= ST_STOP;
                        end
                    end
                end
                ST_STOP: begin
                    if (m_done) begin
                        issued_q <= 1'b0;
                        unique case (kind_q)
                            TX_INIT: state_q <= ST_IDLE;
                            TX_PCMD: begin
                                state_q <= ST_START;
                                kind_q  <= TX_PDATA;
                            end
                            default: begin
                                if (last_page) begin
                                    state_q <= ST_IDLE;
                                end else begin
                                    state_q <= ST_START;
                                    kind_q  <= TX_PCMD;
                                end
                            end
                        endcase
                    end
                end
                ST_ABORT: begin
                    if (m_done) begin
                        issued_q <= 1'b0;
                        state_q  <= ST_POWERUP;
                    end
                end
                default: state_q <= ST_POWERUP;
            endcase
        end
    end

    // Output process
    always_comb begin
        m_start    = 1'b0;
        m_write    = 1'b0;
        m_stop     = 1'b0;
        m_byte     = 8'h00;
        fb_rd_en   = 1'b0;
        rd_col     = idx + 1'b1;
        frame_done = 1'b0;
        unique case (state_q)
            ST_START: m_start = !issued_q;
            ST_ADDR: begin
                m_write = !issued_q;
                m_byte  = {slave_sel ? DEV_ADDR_HI : DEV_ADDR_LO, 1'b0};
            end
            ST_CTRL: begin
                m_write  = !issued_q;
                m_byte   = (kind_q == TX_PDATA) ? CTRL_DATA : CTRL_CMD;
                rd_col   = '0;
                fb_rd_en = (kind_q == TX_PDATA) && m_done && !m_ack_err;
            end
            ST_BODY: begin
                m_write  = !issued_q;
                fb_rd_en = (kind_q == TX_PDATA) && m_done && !m_ack_err && !last_byte;
                unique case (kind_q)
                    TX_INIT: m_byte = init_byte;
                    TX_PCMD: begin
                        if (idx == '0) begin
                            m_byte = PAGE_SEL_BASE | 8'(page);
                        end else if (idx == IDX_W'(1)) begin
                            m_byte = COL_LOW_ZERO;
                        end else begin
                            m_byte = COL_HIGH_ZERO;
                        end
                    end
                    default: m_byte = fb_rd_data;
                endcase
            end
            ST_STOP: begin
                m_stop     = !issued_q;
                frame_done = m_done && (kind_q == TX_PDATA) && last_page;
            end
            ST_ABORT: m_stop = !issued_q;
            default: ;
        endcase
    end

    assign req_any  = m_start || m_write || m_stop;
    assign fb_addr  = FB_AW'(int'(page) * COLS + int'(rd_col));
    assign link_err = err_q;

endmodule

// File: rtl/oled_refresh_seq_chk.sv
module oled_refresh_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic m_start,
    input logic m_write,
    input logic m_stop,
    input logic m_done,
    input logic m_ack_err,
    input logic fb_rd_en,
    input logic frame_done,
    input logic link_err
);
    logic pending_q;
    logic last_wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            last_wr_q <= 1'b0;
        end else if (m_start || m_write || m_stop) begin
            pending_q <= 1'b1;
            last_wr_q <= m_write;
        end else if (m_done) begin
            pending_q <= 1'b0;
        end
    end

    // R11
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({m_start, m_write, m_stop}) <= 1);

    // R11
    req_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> !(m_start || m_write || m_stop));

    // R6
    rd_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd_en |=> m_write);

    // R7
    frame_done_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (m_done && pending_q && !last_wr_q));

    // R9
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_done && m_ack_err && pending_q && last_wr_q) |=> m_stop);

    // R9
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_err) |-> $past(m_done && m_ack_err));

endmodule

bind oled_refresh_seq oled_refresh_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_start    (m_start),
    .m_write    (m_write),
    .m_stop     (m_stop),
    .m_done     (m_done),
    .m_ack_err  (m_ack_err),
    .fb_rd_en   (fb_rd_en),
    .frame_done (frame_done),
    .link_err   (link_err)
);

// File: tb/oled_refresh_seq_tb_top.sv
module oled_refresh_seq_tb_top;
    localparam int PWRUP = 40;
    localparam int LAT   = 3;
    localparam int TOK_START = 256;
    localparam int TOK_STOP  = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slave_sel = 1'b0;
    logic       orient_en = 1'b1;
    logic       auto_refresh = 1'b0;
    logic       frame_req = 1'b0;
    logic       m_start, m_write, m_stop;
    logic [7:0] m_byte;
    logic       m_done = 1'b0;
    logic       m_ack_err = 1'b0;
    logic       fb_rd_en;
    logic [9:0] fb_addr;
    logic [7:0] fb_rd_data = 8'h00;
    logic       frame_done;
    logic       link_err;

    int    total = 0;
    int    bad = 0;
    int    fd_count = 0;
    int    err_at = 0;
    int    wr_seen = 0;
    int    lat_cnt = 0;
    logic  pend_err = 1'b0;
    bit    finished = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    oled_refresh_seq #(.PWRUP_CYCLES(PWRUP)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .slave_sel    (slave_sel),
        .orient_en    (orient_en),
        .auto_refresh (auto_refresh),
        .frame_req    (frame_req),
        .m_start      (m_start),
        .m_write      (m_write),
        .m_stop       (m_stop),
        .m_byte       (m_byte),
        .m_done       (m_done),
        .m_ack_err    (m_ack_err),
        .fb_rd_en     (fb_rd_en),
        .fb_addr      (fb_addr),
        .fb_rd_data   (fb_rd_data),
        .frame_done   (frame_done),
        .link_err     (link_err)
    );

    function automatic logic [7:0] fb_val(int a);
        return 8'((a * 7) + (a >> 7) + 8'h5A);
    endfunction

    // Framebuffer model: one-cycle synchronous read
    always @(posedge clk) begin
        if (fb_rd_en) fb_rd_data <= fb_val(int'(fb_addr));
    end

    // Byte-level master model
    always @(posedge clk) begin
        m_done    <= 1'b0;
        m_ack_err <= 1'b0;
        if (!rst_n) begin
            lat_cnt  <= 0;
            pend_err <= 1'b0;
        end else if (m_start || m_write || m_stop) begin
            lat_cnt  <= LAT;
            pend_err <= m_write && (err_at != 0) && (wr_seen + 1 == err_at);
            if (m_write && err_at != 0) wr_seen <= wr_seen + 1;
        end else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                m_done    <= 1'b1;
                m_ack_err <= pend_err;
            end
        end
        if (err_at == 0) wr_seen <= 0;
    end

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops expected tokens as the design issues requests
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_done) fd_count++;
            if (m_start || m_write || m_stop) begin
                int tok;
                tok = m_start ? TOK_START : (m_stop ? TOK_STOP : int'(m_byte));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected request", tok, -1);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(tok == e, t, tok, e);
                end
            end
        end
    end

    task automatic push(int v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic exp_init(bit sel, bit orient);
        int lst[25] = '{8'hAE, 8'hD5, 8'h80, 8'hA8, 8'h3F, 8'hD3, 8'h00, 8'h40, 8'h8D,
                        8'h14, 8'h20, 8'h02, 8'hA1, 8'hC8, 8'hDA, 8'h12, 8'h81, 8'hCF,
                        8'hD9, 8'hF1, 8'hDB, 8'h40, 8'hA4, 8'hA6, 8'hAF};
        push(TOK_START, "R3 init start");
        push(sel ? 8'h7A : 8'h78, "R2 address");
        push(8'h00, "R3 command control");
        for (int i = 0; i < 25; i++) begin
            int v;
            v = lst[i];
            if (!orient && i == 12) v = 8'hA0;
            if (!orient && i == 13) v = 8'hC0;
            push(v, (i == 12 || i == 13) ? "R4 orientation" : "R3 init list");
        end
        push(TOK_STOP, "R3 init stop");
    endtask

    task automatic exp_page(bit sel, int p);
        push(TOK_START, "R5 page start");
        push(sel ? 8'h7A : 8'h78, "R2 address");
        push(8'h00, "R5 command control");
        push(8'hB0 | p, "R5 page select");
        push(8'h00, "R5 column low");
        push(8'h10, "R5 column high");
        push(TOK_STOP, "R5 page stop");
        push(TOK_START, "R6 data start");
        push(sel ? 8'h7A : 8'h78, "R2 address");
        push(8'h40, "R6 data control");
        for (int c = 0; c < 128; c++) push(int'(fb_val(p * 128 + c)), "R6 data byte");
        push(TOK_STOP, "R6 data stop");
    endtask

    task automatic exp_frame(bit sel);
        for (int p = 0; p < 8; p++) exp_page(sel, p);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (LAT + 6) @(negedge clk);
    endtask

    task automatic do_reset(bit sel, bit orient);
        int cyc;
        @(negedge clk);
        rst_n = 1'b0;
        slave_sel = sel;
        orient_en = orient;
        auto_refresh = 1'b0;
        frame_req = 1'b0;
        err_at = 0;
        exp_q.delete();
        tag_q.delete();
        repeat (3) @(negedge clk);
        check(!m_start && !m_write && !m_stop && !fb_rd_en && !frame_done && !link_err,
              "R1 reset outputs", {m_start, m_write, m_stop, fb_rd_en, frame_done, link_err}, 0);
        exp_init(sel, orient);
        rst_n = 1'b1;
        cyc = 0;
        while (!(m_start || m_write || m_stop) && cyc < 10 * PWRUP) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc >= PWRUP, "R1 power-up wait", cyc, PWRUP);
        check(m_start, "R1 first request is start", m_start, 1);
    endtask

    initial begin
        int fd0;
        // Bring-up with address 0x3C and orientation on
        do_reset(1'b0, 1'b1);
        drain();
        // R8: idle without request stays quiet
        repeat (300) @(negedge clk);
        check(exp_q.size() == 0 && !m_start, "R8 idle quiet", m_start, 0);

        // R5 R6 R7: single frame on request
        fd0 = fd_count;
        exp_frame(1'b0);
        frame_req = 1'b1;
        @(negedge clk);
        frame_req = 1'b0;
        drain();
        check(fd_count - fd0 == 1, "R7 one frame_done", fd_count - fd0, 1);
        check(link_err == 1'b0, "R10 no error", link_err, 0);

        // R8: auto refresh runs two frames back to back
        fd0 = fd_count;
        exp_frame(1'b0);
        exp_frame(1'b0);
        auto_refresh = 1'b1;
        while (fd_count - fd0 < 2) @(negedge clk);
        auto_refresh = 1'b0;
        drain();
        check(fd_count - fd0 == 2, "R8 auto refresh frames", fd_count - fd0, 2);

        // R9: refuse page 1 command address byte (write #136)
        fd0 = fd_count;
        exp_page(1'b0, 0);
        push(TOK_START, "R9 aborted start");
        push(8'h78, "R9 refused address");
        push(TOK_STOP, "R9 abort stop");
        exp_init(1'b0, 1'b1);
        err_at = 136;
        frame_req = 1'b1;
        @(negedge clk);
        frame_req = 1'b0;
        drain();
        err_at = 0;
        check(link_err == 1'b1, "R9 link_err set", link_err, 1);
        check(fd_count == fd0, "R9 no frame_done", fd_count - fd0, 0);

        // R10: next good frame clears the flag
        exp_frame(1'b0);
        frame_req = 1'b1;
        @(negedge clk);
        frame_req = 1'b0;
        drain();
        check(link_err == 1'b0, "R10 link_err cleared", link_err, 0);
        check(fd_count - fd0 == 1, "R7 frame after recovery", fd_count - fd0, 1);

        // R2 R4: address 0x3D, orientation off
        do_reset(1'b1, 1'b0);
        drain();
        exp_frame(1'b1);
        frame_req = 1'b1;
        @(negedge clk);
        frame_req = 1'b0;
        drain();
        check(exp_q.size() == 0, "R2 queue empty", exp_q.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", exp_q.size(), 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule